// File: doc/BRIEF.md
# I2C Master STOP Condition Generator

This block produces the STOP condition for the master side of an I2C bus. Both lines are open-drain. For each line the block has a drive-low enable output, and it reads the real line level back on a separate input through a two-stage synchronizer. A one-cycle request starts the sequence. The block pulls SDA low and holds SCL low until SDA reads low. It then lets SCL float and waits until SCL reads high, so a slow device can stretch the clock. It times one baud period from a 7-bit reload value and releases SDA. It holds SDA released for a second period, and then checks that SDA really is high.

At every step the block watches for another master that drives a zero. If SCL drops while the block still holds SDA low, or if SDA reads low at the end of the second period, the block sets a collision flag. It then releases both lines at once and returns to idle. A clean finish sets a completion flag instead. Both flags stay set until a one-cycle clear pulse.

Top module: `i2c_stop_gen`

## Requirements
- R1: During and directly after reset, sdaDriveLow, sclDriveLow, busy, stopDoneFlag and collisionFlag are all 0.
- R2: A stopReq pulse in idle makes sdaDriveLow, sclDriveLow and busy read 1 in the next cycle.
- R3: sclDriveLow drops exactly 3 cycles after sdaDriveLow rises: two synchronizer stages, then one decision cycle after SDA reads low.
- R4: sdaDriveLow drops exactly reload+4 cycles after the SCL line first reads high. The baud period is reload+1 cycles. A device that stretches SCL low delays this count, and SDA stays driven low while SCL is held.
- R5: A reload value of 0 gives a one-cycle baud period, so SDA is released 4 cycles after SCL reads high.
- R6: On a clean finish, stopDoneFlag sets and busy clears max(reload,2)+1 cycles after sdaDriveLow drops. The second period is never shorter than the synchronizer delay plus one cycle.
- R7: If SDA reads low at the end of the second period, collisionFlag sets in the same cycle that R6 gives, and stopDoneFlag stays 0.
- R8: If the SCL line is pulled low after SCL was seen high and before SDA is released, collisionFlag sets 3 cycles later. In that same cycle both drive enables and busy go to 0.
- R9: Both flags stay set until a flagClr pulse, which clears both. A flag set event in the same cycle as flagClr wins over the clear.
- R10: A stopReq while busy is ignored. The running sequence keeps its timing, and no new sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stopReq | input | 1 | One-cycle request to generate a STOP |
| flagClr | input | 1 | One-cycle clear of both flags |
| reloadVal | input | 7 | Baud reload value; the period is reloadVal+1 cycles |
| sdaIn | input | 1 | SDA line level (asynchronous) |
| sclIn | input | 1 | SCL line level (asynchronous) |
| sdaDriveLow | output | 1 | Pull SDA low when 1 |
| sclDriveLow | output | 1 | Pull SCL low when 1 |
| busy | output | 1 | Sequence in progress |
| stopDoneFlag | output | 1 | Sticky flag: STOP completed |
| collisionFlag | output | 1 | Sticky flag: bus collision seen |

## Verification
Every result has a fixed delay. The drive outputs follow a request after 1 cycle. SCL is released 3 cycles after SDA is driven low. SDA is released reload+4 cycles after the SCL line reads high. Completion or an SDA collision comes max(reload,2)+1 cycles after the SDA release, and an SCL collision comes 3 cycles after the line drops. The bench counts falling clock edges from the falling edge at which the causing line or output change is first seen. It compares that count with the exact figure above, so an event that comes one cycle early or late is caught. It models the open-drain bus itself, stretches SCL and injects foreign zeros by driving each line low from its side.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SDA_LOW,
    ST_SCL_REL,
    ST_HOLD,
    ST_SETTLE
  } stopState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBaud;
    logic loadGuard;
    logic setDone;
    logic setColl;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic sdaHigh;
    logic sclHigh;
    logic baudDone;
    logic guardDone;
  } dpStat_t;

endpackage

// File: rtl/i2c_stop_dp.sv
module i2c_stop_dp
  import i2c_stop_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdaIn,
  input  logic                sclIn,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                flagClr,
  input  dpCmd_t              cmd,
  output dpStat_t             stat,
  output logic                stopDoneFlag,
  output logic                collisionFlag
);

  localparam int GUARD_W = $clog2(SYNC_STAGES + 1);
  localparam logic [GUARD_W-1:0] GUARD_LOAD = GUARD_W'(SYNC_STAGES);

  logic [SYNC_STAGES-1:0] sdaSh, sclSh;
  logic [RELOAD_W-1:0]    baudCnt;
  logic [GUARD_W-1:0]     guardCnt;

  // line synchronizers, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaSh <= '1;
      sclSh <= '1;
    end else begin
      sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
    end
  end

  // baud period counter: load N, done at zero, never wraps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                baudCnt <= '0;
    else if (cmd.loadBaud)    baudCnt <= reloadVal;
    else if (baudCnt != '0)   baudCnt <= baudCnt - 1'b1;
  end

  // guard counter covers the synchronizer delay after SDA release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                guardCnt <= '0;
    else if (cmd.loadGuard)   guardCnt <= GUARD_LOAD;
    else if (guardCnt != '0)  guardCnt <= guardCnt - 1'b1;
  end

  // sticky flags, set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopDoneFlag  <= 1'b0;
      collisionFlag <= 1'b0;
    end else begin
      stopDoneFlag  <= cmd.setDone | (stopDoneFlag  & ~flagClr);
      collisionFlag <= cmd.setColl | (collisionFlag & ~flagClr);
    end
  end

  always_comb begin
    stat.sdaHigh   = sdaSh[SYNC_STAGES-1];
    stat.sclHigh   = sclSh[SYNC_STAGES-1];
    stat.baudDone  = (baudCnt == '0);
    stat.guardDone = (guardCnt == '0);
  end

endmodule

// File: rtl/i2c_stop_ctrl.sv
module i2c_stop_ctrl
  import i2c_stop_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    stopReq,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    sdaDriveLow,
  output logic    sclDriveLow,
  output logic    busy
);

  stopState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE:    if (stopReq) nextState = ST_SDA_LOW;
      ST_SDA_LOW: if (!stat.sdaHigh) nextState = ST_SCL_REL;
      ST_SCL_REL: if (stat.sclHigh) begin
                    cmd.loadBaud = 1'b1;
                    nextState    = ST_HOLD;
                  end
      ST_HOLD: begin
        if (!stat.sclHigh) begin
          cmd.setColl = 1'b1;
          nextState   = ST_IDLE;
        end else if (stat.baudDone) begin
          cmd.loadBaud  = 1'b1;
          cmd.loadGuard = 1'b1;
          nextState     = ST_SETTLE;
        end
      end
      ST_SETTLE: if (stat.baudDone && stat.guardDone) begin
                   cmd.setDone = stat.sdaHigh;
                   cmd.setColl = !stat.sdaHigh;
                   nextState   = ST_IDLE;
                 end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    sdaDriveLow = (state == ST_SDA_LOW) || (state == ST_SCL_REL) || (state == ST_HOLD);
    sclDriveLow = (state == ST_SDA_LOW);
    busy        = (state != ST_IDLE);
  end

endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen
  import i2c_stop_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stopReq,
  input  logic                flagClr,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                sdaIn,
  input  logic                sclIn,
  output logic                sdaDriveLow,
  output logic                sclDriveLow,
  output logic                busy,
  output logic                stopDoneFlag,
  output logic                collisionFlag
);

  dpCmd_t  cmd;
  dpStat_t stat;

  i2c_stop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .stat(stat), .cmd(cmd),
    .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow), .busy(busy)
  );

  i2c_stop_dp #(.RELOAD_W(RELOAD_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .sclIn(sclIn),
    .reloadVal(reloadVal), .flagClr(flagClr), .cmd(cmd), .stat(stat),
    .stopDoneFlag(stopDoneFlag), .collisionFlag(collisionFlag)
  );

endmodule

// File: rtl/i2c_stop_chk.sv
module i2c_stop_chk (
  input logic clk,
  input logic rstN,
  input logic stopReq,
  input logic flagClr,
  input logic sdaDriveLow,
  input logic sclDriveLow,
  input logic busy,
  input logic stopDoneFlag,
  input logic collisionFlag
);

  // R2: request in idle starts the sequence with both lines pulled low
  a_r2_req_starts: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopReq) |=> (busy && sdaDriveLow && sclDriveLow));

  // R3: SCL is only released while SDA is still held low
  a_r3_scl_after_sda: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclDriveLow) && busy) |-> sdaDriveLow);

  // R6: completion leaves the bus released and the block idle
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopDoneFlag) |-> (!busy && !sdaDriveLow && !sclDriveLow && !$rose(collisionFlag)));

  // R8: collision releases both lines and ends the sequence
  a_r8_coll_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collisionFlag) |-> (!busy && !sdaDriveLow && !sclDriveLow));

  // R9: flags hold without a clear
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stopDoneFlag && !flagClr) |=> stopDoneFlag);
  a_r9_coll_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (collisionFlag && !flagClr) |=> collisionFlag);

  // R10: a request while busy does not break the running sequence
  a_r10_busy_req: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stopReq) |=> (busy || $rose(stopDoneFlag) || $rose(collisionFlag)));

endmodule

bind i2c_stop_gen i2c_stop_chk u_chk (.*);

// File: tb/i2c_stop_gen_tb.sv
module i2c_stop_gen_tb;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, stopReq = 1'b0, flagClr = 1'b0;
  logic [6:0] reloadVal = '0;
  logic extSdaLow = 1'b0, extSclLow = 1'b0;
  logic sdaDriveLow, sclDriveLow, busy, stopDoneFlag, collisionFlag;
  logic sdaLine, sclLine;
  int total = 0, bad = 0;
  bit finished = 0;

  assign sdaLine = !(sdaDriveLow || extSdaLow);
  assign sclLine = !(sclDriveLow || extSclLow);

  i2c_stop_gen u_dut (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .flagClr(flagClr),
    .reloadVal(reloadVal), .sdaIn(sdaLine), .sclIn(sclLine),
    .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow), .busy(busy),
    .stopDoneFlag(stopDoneFlag), .collisionFlag(collisionFlag)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int max2(int n);
    return (n > 2) ? n : 2;
  endfunction

  // start a sequence and check R2/R3; returns at the edge where SCL release is seen
  task automatic startSeq();
    int cnt;
    @(negedge clk) stopReq = 1'b1;
    @(negedge clk) stopReq = 1'b0;
    chk("R2 sda drive", sdaDriveLow, 1);
    chk("R2 scl drive", sclDriveLow, 1);
    chk("R2 busy", busy, 1);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (sclDriveLow && cnt < 100);
    chk("R3 scl release delay", cnt, 3);
  endtask

  task automatic clearFlags();
    @(negedge clk) flagClr = 1'b1;
    @(negedge clk) flagClr = 1'b0;
    chk("R9 clear done", stopDoneFlag, 0);
    chk("R9 clear coll", collisionFlag, 0);
  endtask

  task automatic runNormal(int n, int stretch, bit inject);
    int cnt;
    string tagR;
    tagR = (n == 0) ? "R5 sda release" : "R4 sda release";
    reloadVal = 7'(n);
    extSclLow = (stretch > 0);
    startSeq();
    if (stretch > 0) begin
      repeat (stretch) @(negedge clk);
      chk("R4 sda held while stretched", sdaDriveLow, 1);
      chk("R4 busy while stretched", busy, 1);
      extSclLow = 1'b0;
    end
    cnt = 0;
    do begin
      @(negedge clk); cnt++;
      stopReq = inject && (cnt == 3);
    end while (sdaDriveLow && cnt < 1000);
    stopReq = 1'b0;
    chk(tagR, cnt, n + 4);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!stopDoneFlag && cnt < 1000);
    chk("R6 done delay", cnt, max2(n) + 1);
    chk("R6 busy clear", busy, 0);
    chk("R6 no collision", collisionFlag, 0);
    repeat (5) @(negedge clk);
    chk("R9 done sticky", stopDoneFlag, 1);
    if (inject) chk("R10 no restart", busy, 0);
    clearFlags();
  endtask

  task automatic collSda(int n);
    int cnt;
    reloadVal = 7'(n);
    startSeq();
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (sdaDriveLow && cnt < 1000);
    extSdaLow = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!collisionFlag && cnt < 1000);
    chk("R7 collision delay", cnt, max2(n) + 1);
    chk("R7 no done", stopDoneFlag, 0);
    chk("R7 busy clear", busy, 0);
    extSdaLow = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 coll sticky", collisionFlag, 1);
    clearFlags();
  endtask

  task automatic collScl(int n);
    int cnt;
    reloadVal = 7'(n);
    startSeq();
    repeat (5) @(negedge clk);
    extSclLow = 1'b1;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!collisionFlag && cnt < 1000);
    chk("R8 collision delay", cnt, 3);
    chk("R8 sda released", sdaDriveLow, 0);
    chk("R8 scl released", sclDriveLow, 0);
    chk("R8 busy clear", busy, 0);
    chk("R8 no done", stopDoneFlag, 0);
    extSclLow = 1'b0;
    clearFlags();
  endtask

  task automatic resetCheck();
    repeat (3) @(negedge clk);
    chk("R1 sda in reset", sdaDriveLow, 0);
    chk("R1 scl in reset", sclDriveLow, 0);
    chk("R1 busy in reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 done after reset", stopDoneFlag, 0);
    chk("R1 coll after reset", collisionFlag, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    resetCheck();
    runNormal(5, 0, 0);
    runNormal(0, 0, 0);
    runNormal(1, 0, 0);
    runNormal(127, 0, 0);
    runNormal(6, 7, 0);
    runNormal(10, 0, 1);
    collSda(4);
    collSda(0);
    collScl(20);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule